// File: doc/BRIEF.md
# DAC Output Update Scheduler

This block decides when a new code for an 8-bit current-output converter reaches the converter's input latch. Software writes a code into a holding register through a write strobe. A 3-bit mode field then picks the moment the held code is copied to the output latch. The copy can happen at once on the write, or on the overflow pulse of one of four timers, or on a chosen edge of an external conversion-start pin. Timer and pin triggers make the sample instants independent of interrupt latency and instruction timing, so waveform updates are free of jitter.

A separate 2-bit field selects the full-scale current. The block does not interpret that field; it registers it and passes it on as a range code. An output code of N gives N/256 of the selected full scale, so 0x00 gives zero and 0xFF gives 255/256.

Top module: `dac_update_sched`

## Requirements
- R1: While `rst` is high at a rising clock edge, `dac_code` becomes 0x00 and `dac_range` becomes 2'b00 after that edge, and the held code is cleared to 0x00.
- R2: With `upd_mode` = 3'b111, a write of value V (`wr_en` high, `wr_data` = V) makes `dac_code` equal V right after the same clock edge.
- R3: With `upd_mode` = 3'b0ii (ii = 0..3), a single-cycle pulse on `tmr_ovf[ii]` copies the held code to `dac_code` at that clock edge.
- R4: With `upd_mode` = 3'b100, 3'b101 or 3'b110, a rising edge, a falling edge, or either edge of `conv_pin` copies the held code to `dac_code`. The pin passes through two synchronizing flops, so `dac_code` changes after the third rising clock edge that follows the pin change.
- R5: In every mode except 3'b111, `dac_code` keeps its value after a write, and after any trigger that the mode does not select (the other timers, and the pin edges the mode does not select).
- R6: When several writes come before a selected trigger, only the last written value reaches `dac_code`.
- R7: When a write and the selected trigger fall in the same cycle, the value written in that cycle reaches `dac_code`.
- R8: A selected trigger with no write since the last transfer leaves `dac_code` unchanged.
- R9: `dac_range` equals the value `range_sel` had at the previous clock edge. The codes are 00 = 0.25 mA, 01 = 0.5 mA, 10 = 1 mA and 11 = 2 mA full scale.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the held code |
| wr_data | input | 8 | Code to write |
| upd_mode | input | 3 | Update mode: 0ii = timer ii, 100 = pin rise, 101 = pin fall, 110 = both edges, 111 = immediate |
| range_sel | input | 2 | Full-scale range select |
| tmr_ovf | input | 4 | Single-cycle overflow pulses of timers 0..3 |
| conv_pin | input | 1 | Asynchronous external conversion-start pin |
| dac_code | output | 8 | Code in the output latch |
| dac_range | output | 2 | Registered range code |

## Verification
The hardest case to reach is a pin-edge transfer, because the pin edge only acts three clock edges after the pin changes. During those cycles, the held code and the mode must give a result that differs from every trigger the mode does not select. The bench sweeps all eight modes. In each mode it writes several distinct codes and then fires every timer pulse and both pin edges in turn, waiting through the synchronizer delay after each pin edge. A reference model tracks which events should copy the code. Separate runs place a write in the same cycle as a timer pulse, and stack several writes ahead of a single trigger.

// File: rtl/dus_pkg.sv
package dus_pkg;
  localparam int unsigned NUM_TMR = 4;

  typedef enum logic [2:0] {
    MODE_TMR0 = 3'b000,
    MODE_TMR1 = 3'b001,
    MODE_TMR2 = 3'b010,
    MODE_TMR3 = 3'b011,
    MODE_RISE = 3'b100,
    MODE_FALL = 3'b101,
    MODE_BOTH = 3'b110,
    MODE_NOW  = 3'b111
  } upd_mode_e;
endpackage

// File: rtl/dus_pin_sync.sv
module dus_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_async,
  output logic rise_p,
  output logic fall_p
);
  // flop chain: STAGES synchronizer flops plus one history flop
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-1:0], pin_async};
  end

  logic sync_now, sync_prev;
  assign sync_now  = chain_q[STAGES-1];
  assign sync_prev = chain_q[STAGES];
  assign rise_p    = sync_now & ~sync_prev;
  assign fall_p    = ~sync_now & sync_prev;
endmodule

// File: rtl/dus_trig_sel.sv
module dus_trig_sel
  import dus_pkg::*;
(
  input  upd_mode_e          mode,
  input  logic [NUM_TMR-1:0] tmr_ovf,
  input  logic               rise_p,
  input  logic               fall_p,
  input  logic               wr_en,
  output logic               load
);
  always_comb begin
    unique case (mode)
      MODE_TMR0, MODE_TMR1,
      MODE_TMR2, MODE_TMR3: load = tmr_ovf[mode[1:0]];
      MODE_RISE:            load = rise_p;
      MODE_FALL:            load = fall_p;
      MODE_BOTH:            load = rise_p | fall_p;
      MODE_NOW:             load = wr_en;
      default:              load = 1'b0;
    endcase
  end
endmodule

// File: rtl/dus_latch_pair.sv
module dus_latch_pair #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             load,
  output logic [WIDTH-1:0] code_q
);
  logic [WIDTH-1:0] hold_q;
  logic [WIDTH-1:0] next_src;

  // a write in the load cycle bypasses the holding register
  assign next_src = wr_en ? wr_data : hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      code_q <= '0;
    end else begin
      if (wr_en) hold_q <= wr_data;
      if (load)  code_q <= next_src;
    end
  end
endmodule

// File: rtl/dac_update_sched.sv
module dac_update_sched
  import dus_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned RANGE_W     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [2:0]         upd_mode,
  input  logic [RANGE_W-1:0] range_sel,
  input  logic [NUM_TMR-1:0] tmr_ovf,
  input  logic               conv_pin,
  output logic [DATA_W-1:0]  dac_code,
  output logic [RANGE_W-1:0] dac_range
);
  logic pin_rise, pin_fall, do_load;

  dus_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .pin_async (conv_pin),
    .rise_p    (pin_rise),
    .fall_p    (pin_fall)
  );

  dus_trig_sel u_sel (
    .mode    (upd_mode_e'(upd_mode)),
    .tmr_ovf (tmr_ovf),
    .rise_p  (pin_rise),
    .fall_p  (pin_fall),
    .wr_en   (wr_en),
    .load    (do_load)
  );

  dus_latch_pair #(.WIDTH(DATA_W)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .load    (do_load),
    .code_q  (dac_code)
  );

  always_ff @(posedge clk) begin
    if (rst) dac_range <= '0;
    else     dac_range <= range_sel;
  end
endmodule

// File: rtl/dus_checker.sv
module dus_checker #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned RANGE_W = 2,
  parameter int unsigned NTMR    = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [DATA_W-1:0]  wr_data,
  input logic [2:0]         upd_mode,
  input logic [RANGE_W-1:0] range_sel,
  input logic [NTMR-1:0]    tmr_ovf,
  input logic [DATA_W-1:0]  dac_code,
  input logic [RANGE_W-1:0] dac_range
);
  // shadow of the last written value, kept independently of the design
  logic [DATA_W-1:0] shadow_q;
  always_ff @(posedge clk) begin
    if (rst)        shadow_q <= '0;
    else if (wr_en) shadow_q <= wr_data;
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (dac_code == '0 && dac_range == '0));

  a_r2_immediate: assert property (@(posedge clk) disable iff (rst)
    (upd_mode == 3'b111 && wr_en) |=> dac_code == $past(wr_data));

  a_r3_timer_copy: assert property (@(posedge clk) disable iff (rst)
    (!upd_mode[2] && tmr_ovf[upd_mode[1:0]])
      |=> dac_code == $past(wr_en ? wr_data : shadow_q));

  a_r5_timer_hold: assert property (@(posedge clk) disable iff (rst)
    (!upd_mode[2] && !tmr_ovf[upd_mode[1:0]]) |=> $stable(dac_code));

  a_r9_range_pass: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> dac_range == $past(range_sel));
endmodule

bind dac_update_sched dus_checker #(
  .DATA_W (DATA_W),
  .RANGE_W(RANGE_W),
  .NTMR   (dus_pkg::NUM_TMR)
) u_dus_checker (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .upd_mode (upd_mode),
  .range_sel(range_sel),
  .tmr_ovf  (tmr_ovf),
  .dac_code (dac_code),
  .dac_range(dac_range)
);

// File: tb/dac_update_sched_tb_top.sv
module dac_update_sched_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [2:0] upd_mode = 3'b111;
  logic [1:0] range_sel = '0;
  logic [3:0] tmr_ovf = '0;
  logic       conv_pin = 1'b0;
  logic [7:0] dac_code;
  logic [1:0] dac_range;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] m_hold = '0;
  logic [7:0] m_code = '0;

  always #10 clk = ~clk;

  dac_update_sched dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .upd_mode(upd_mode), .range_sel(range_sel), .tmr_ovf(tmr_ovf),
    .conv_pin(conv_pin), .dac_code(dac_code), .dac_range(dac_range)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_code(input string req);
    n_cmp++;
    if (dac_code !== m_code) begin
      n_bad++;
      $display("FAIL %s mode=%b code=%h expected=%h", req, upd_mode, dac_code, m_code);
    end
  endtask

  task automatic chk_range(input string req, input logic [1:0] exp);
    n_cmp++;
    if (dac_range !== exp) begin
      n_bad++;
      $display("FAIL %s range=%b expected=%b", req, dac_range, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] v);
    wr_en = 1'b1; wr_data = v;
    tick();
    wr_en = 1'b0;
    m_hold = v;
    if (upd_mode == 3'b111) m_code = v;
  endtask

  function automatic string tag_of(input logic hit);
    return hit ? (upd_mode[2] ? "R4" : "R3") : "R5";
  endfunction

  task automatic do_timer(input int i, input logic with_wr, input logic [7:0] v);
    logic hit;
    tmr_ovf[i] = 1'b1;
    if (with_wr) begin wr_en = 1'b1; wr_data = v; end
    tick();
    tmr_ovf = '0; wr_en = 1'b0;
    if (with_wr) m_hold = v;
    hit = (!upd_mode[2] && upd_mode[1:0] == i[1:0]);
    if (hit || (with_wr && upd_mode == 3'b111)) m_code = m_hold;
    chk_code(with_wr ? "R7" : tag_of(hit));
  endtask

  task automatic do_pin(input logic v);
    logic hit;
    logic rise;
    rise = v & ~conv_pin;
    conv_pin = v;
    repeat (3) tick();
    hit = (upd_mode == 3'b110) ||
          (upd_mode == 3'b100 && rise) ||
          (upd_mode == 3'b101 && !rise);
    if (hit) m_code = m_hold;
    chk_code(tag_of(hit));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] vals [5];
    vals[0] = 8'h00; vals[1] = 8'hFF; vals[2] = 8'h80; vals[3] = 8'h01; vals[4] = 8'h00;
    // R1: reset state, with a write held during reset
    wr_en = 1'b1; wr_data = 8'hA5; range_sel = 2'b11;
    repeat (3) tick();
    n_cmp++;
    if (dac_code !== 8'h00 || dac_range !== 2'b00) begin
      n_bad++;
      $display("FAIL R1 code=%h range=%b expected=00 00", dac_code, dac_range);
    end
    wr_en = 1'b0; range_sel = 2'b00;
    rst = 1'b0;
    tick();
    chk_code("R1");

    // R9: range codes 00=0.25mA 01=0.5mA 10=1mA 11=2mA passed through
    for (int r = 0; r < 4; r++) begin
      range_sel = r[1:0];
      tick();
      chk_range("R9", r[1:0]);
    end
    range_sel = 2'b10;

    // sweep every mode with each write value and every trigger
    for (int m = 0; m < 8; m++) begin
      upd_mode = m[2:0];
      tick();
      vals[4] = 8'(m * 37 + 5);
      for (int k = 0; k < 5; k++) begin
        do_write(vals[k] ^ 8'(m));
        chk_code(upd_mode == 3'b111 ? "R2" : "R5");
        for (int t = 0; t < 4; t++) do_timer(t, 1'b0, 8'h00);
        do_pin(1'b1);
        do_pin(1'b0);
      end
      // R8: retrigger without a write keeps the code
      for (int t = 0; t < 4; t++) begin
        do_timer(t, 1'b0, 8'h00);
        chk_code("R8");
      end
    end

    // R6: several writes, one trigger
    upd_mode = 3'b010;
    tick();
    do_write(8'h11); do_write(8'h22); do_write(8'h3C);
    chk_code("R5");
    tmr_ovf[2] = 1'b1; tick(); tmr_ovf = '0;
    m_code = 8'h3C;
    chk_code("R6");

    // R6 with pin-edge mode
    upd_mode = 3'b101;
    tick();
    do_write(8'h44); do_write(8'h9E);
    do_pin(1'b1);
    do_pin(1'b0);
    chk_code("R6");

    // R7: write and selected timer in the same cycle
    upd_mode = 3'b001;
    tick();
    do_write(8'h0F);
    do_timer(1, 1'b1, 8'h5A);
    do_timer(3, 1'b1, 8'hC3);
    do_timer(1, 1'b0, 8'h00);

    chk_range("R9", 2'b10);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule